// File: doc/BRIEF.md
# Transmit Retry and Abort Controller

This block supervises the transmit attempts of one frame at a time on a shared, collision-prone medium. The serializer signals the first preamble bit, collisions, the end of the frame and a bit-time tick. When a collision arrives early in the frame, the controller drives a jam pattern, waits a random backoff and then asks for a retry. When a collision arrives late, or the frame has already failed its last permitted attempt, it jams, abandons the frame and blocks all further transmission until software has read the outcome.

Each finished frame, whether it was sent or abandoned, loads a status word that clears when it is read. The same event sets a transmit-interrupt flag, and that flag drives the interrupt output unless the mask is set. During a hold after an abort, `tx_req` stays low. Only a status read clears the hold. Nothing on the receive side is involved.

Top module: `tx_retry_ctrl`

## Requirements
- R1: After reset, `tx_req` is 1 and `jam_en`, `retry_req`, `abort`, `irq` and `status` are all 0.
- R2: If `eof` arrives during a frame with no collision, the frame ends. On the next edge, `status` loads with the valid bit set and the late and retry bits clear, the attempt field takes the attempt number, and the interrupt flag sets.
- R3: A collision seen while fewer than LATE_BITS ticks have passed since the `sof` edge counts as early. `jam_en` then stays high for JAM_BITS ticks, followed by a backoff and a one-cycle `retry_req` pulse. The next `sof` starts an attempt with a number one higher.
- R4: After attempt n has collided, the backoff lasts a slot count drawn from an LFSR in the range 0 to 2^min(n,BACKOFF_LIMIT)-1. Each slot is SLOT_BITS ticks long.
- R5: When attempt MAX_ATTEMPTS (16) ends in an early collision, the controller jams and then pulses `abort` with no `retry_req`. `status` then reads valid=1, retry-error=1 and attempts=16.
- R6: A collision seen at LATE_BITS ticks or later jams for JAM_BITS ticks and then aborts with no retry. `status` then shows valid=1 and late=1.
- R7: After an abort, `tx_req` stays 0 until `stat_rd`. While it is 0, `sof` and `col` are ignored: no jam is sent and `status` does not change. After the read, `tx_req` is 1 again.
- R8: `stat_rd` clears `status` and the interrupt flag on the next edge, unless a new frame result loads in that same cycle.
- R9: `irq` equals the interrupt flag AND NOT `int_mask`. A masked flag is kept and appears on `irq` once the mask drops.
- R10: Layout of `status`: bit CNT_W+2 is valid, bit CNT_W+1 is late collision, bit CNT_W is retry error, and bits CNT_W-1:0 hold the attempt count. With the defaults, CNT_W is 5 and `status` is 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One pulse per bit time |
| sof | input | 1 | First preamble bit of an attempt |
| col | input | 1 | Collision seen on the medium |
| eof | input | 1 | Frame finished without collision |
| stat_rd | input | 1 | Status read strobe, clears status |
| int_mask | input | 1 | Masks the interrupt output |
| tx_req | output | 1 | Permission to start an attempt |
| jam_en | output | 1 | Serializer sends the all-zero jam |
| retry_req | output | 1 | One-cycle pulse: resend the frame |
| abort | output | 1 | One-cycle pulse: drop the frame from the FIFO |
| status | output | CNT_W+3 | Frame result word, cleared on read |
| irq | output | 1 | Masked transmit interrupt |

## Verification
The bench builds the controller with LATE_BITS=16, JAM_BITS=4, SLOT_BITS=2 and BACKOFF_LIMIT=3, and MAX_ATTEMPTS stays at 16. With these values, a full run of sixteen collided attempts finishes in a few hundred cycles. The bench also places collisions on both sides of the late boundary, at tick 15 and tick 16. Because the backoff window stays small, the bench can bound every wait between the end of a jam and the retry pulse.

// File: rtl/tx_retry_pkg.sv
// Shared types for the transmit retry controller.
// Assumes nothing beyond the states of the attempt sequencer.
package tx_retry_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XMIT,
        ST_JAM,
        ST_BACKOFF,
        ST_RETRY,
        ST_ABORT,
        ST_HOLD
    } tx_state_e;
endpackage

// File: rtl/tx_bit_timer.sv
// Bit-time counter: clears on request, advances on each tick, saturates.
// Assumes clr has priority over tick.
module tx_bit_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] count
);
    // count ticks since the last clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count <= '0;
        else if (tick && count != {W{1'b1}})
            count <= count + 1'b1;
    end
endmodule

// File: rtl/tx_backoff_lfsr.sv
// Free-running Galois LFSR used to draw backoff slot counts.
// Assumes SEED is non-zero and TAPS is a maximal polynomial for W.
module tx_backoff_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 10,
    parameter logic [W-1:0] SEED = 16'hACE1,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);
    logic [W-1:0] sr;

    // advance the shift register every cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr <= SEED;
        else if (sr[0])
            sr <= (sr >> 1) ^ TAPS;
        else
            sr <= sr >> 1;
    end

    assign rnd = sr[OUT_W-1:0];
endmodule

// File: rtl/tx_status_reg.sv
// Frame status word and transmit interrupt flag, both cleared on read.
// Assumes a load in the same cycle as a read wins over the read.
module tx_status_reg #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             f_late,
    input  logic             f_rtry,
    input  logic [CNT_W-1:0] f_att,
    input  logic             rd,
    output logic [CNT_W+2:0] status,
    output logic             flag
);
    // capture frame result or clear on read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            flag   <= 1'b0;
        end else if (load) begin
            status <= {1'b1, f_late, f_rtry, f_att};
            flag   <= 1'b1;
        end else if (rd) begin
            status <= '0;
            flag   <= 1'b0;
        end
    end
endmodule

// File: rtl/tx_retry_ctrl.sv
// Transmit attempt sequencer: counts attempts, splits early from late
// collisions, jams, backs off, retries or aborts, and holds after abort
// until the status is read. Assumes sof marks the first preamble bit and
// that col and eof arrive only while an attempt is running.
module tx_retry_ctrl
    import tx_retry_pkg::*;
#(
    parameter int          MAX_ATTEMPTS  = 16,
    parameter int          LATE_BITS     = 512,
    parameter int          JAM_BITS      = 32,
    parameter int          SLOT_BITS     = 512,
    parameter int          BACKOFF_LIMIT = 10,
    parameter int          LFSR_W        = 16,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int CNT_W   = $clog2(MAX_ATTEMPTS + 1),
    localparam int STAT_W  = CNT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              sof,
    input  logic              col,
    input  logic              eof,
    input  logic              stat_rd,
    input  logic              int_mask,
    output logic              tx_req,
    output logic              jam_en,
    output logic              retry_req,
    output logic              abort,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    localparam int TMR_MAX = (LATE_BITS > JAM_BITS)
        ? ((LATE_BITS > SLOT_BITS) ? LATE_BITS : SLOT_BITS)
        : ((JAM_BITS > SLOT_BITS) ? JAM_BITS : SLOT_BITS);
    localparam int TMR_W  = $clog2(TMR_MAX + 1);
    localparam int SLOT_W = BACKOFF_LIMIT;

    tx_state_e          state, state_n;
    logic               late_q;
    logic [CNT_W-1:0]   att_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [SLOT_W-1:0]  slot_mask;
    logic [SLOT_W-1:0]  rnd;
    logic [TMR_W-1:0]   tcnt;
    logic               tmr_clr;
    logic               col_late;
    logic               jam_last;
    logic               slot_last;
    logic               stat_load;
    logic               ld_late;
    logic               ld_rtry;
    logic               flag;

    tx_bit_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (bit_tick),
        .count (tcnt)
    );

    tx_backoff_lfsr #(.W(LFSR_W), .OUT_W(SLOT_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    tx_status_reg #(.CNT_W(CNT_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (stat_load),
        .f_late (ld_late),
        .f_rtry (ld_rtry),
        .f_att  (att_q),
        .rd     (stat_rd),
        .status (status),
        .flag   (flag)
    );

    // timing comparisons against the shared bit timer
    assign col_late  = tcnt >= TMR_W'(LATE_BITS);
    assign jam_last  = bit_tick && (tcnt == TMR_W'(JAM_BITS - 1));
    assign slot_last = bit_tick && (tcnt == TMR_W'(SLOT_BITS - 1));

    // backoff window: low min(attempt, limit) bits of the random word
    generate
        for (genvar i = 0; i < SLOT_W; i++) begin : g_mask
            assign slot_mask[i] = (32'(att_q) > i);
        end
    endgenerate

    // next-state selection for the attempt sequence
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (sof) state_n = ST_XMIT;
            ST_XMIT:    if (col) state_n = ST_JAM;
                        else if (eof) state_n = ST_IDLE;
            ST_JAM:     if (jam_last) begin
                            if (late_q || att_q == CNT_W'(MAX_ATTEMPTS))
                                state_n = ST_ABORT;
                            else
                                state_n = ST_BACKOFF;
                        end
            ST_BACKOFF: if (slot_q == '0) state_n = ST_RETRY;
            ST_RETRY:   if (sof) state_n = ST_XMIT;
            ST_ABORT:   state_n = ST_HOLD;
            ST_HOLD:    if (stat_rd) state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // timer restarts on every state change and at each slot boundary
    assign tmr_clr = (state_n != state) || (state == ST_BACKOFF && slot_last);

    // sequencer registers: state, attempt number, late flag, slots left
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            att_q  <= '0;
            late_q <= 1'b0;
            slot_q <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && sof) begin
                att_q  <= CNT_W'(1);
                late_q <= 1'b0;
            end
            if (state == ST_RETRY && sof)
                att_q <= att_q + 1'b1;
            if (state == ST_XMIT && col)
                late_q <= col_late;
            if (state == ST_JAM && jam_last)
                slot_q <= rnd & slot_mask;
            else if (state == ST_BACKOFF && slot_q != '0 && slot_last)
                slot_q <= slot_q - 1'b1;
        end
    end

    // outputs decoded from the sequencer state
    assign tx_req    = (state == ST_IDLE) || (state == ST_RETRY);
    assign jam_en    = (state == ST_JAM);
    assign retry_req = (state == ST_BACKOFF) && (slot_q == '0);
    assign abort     = (state == ST_ABORT);

    // status load on a clean end of frame or on abort
    assign stat_load = (state == ST_XMIT && !col && eof) || (state == ST_ABORT);
    assign ld_late   = (state == ST_ABORT) && late_q;
    assign ld_rtry   = (state == ST_ABORT) && !late_q;

    assign irq = flag && !int_mask;
endmodule

// File: rtl/tx_retry_chk.sv
// Checker for the transmit retry controller, bound to its top module.
// Assumes it sees the top's ports and its status load strobe.
module tx_retry_chk #(
    parameter int MAX_ATTEMPTS = 16,
    parameter int CNT_W        = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat_rd,
    input logic             int_mask,
    input logic             tx_req,
    input logic             jam_en,
    input logic             retry_req,
    input logic             abort,
    input logic [CNT_W+2:0] status,
    input logic             irq,
    input logic             stat_load
);
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        int_mask |-> !irq);

    a_r3_retry_single: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req);

    a_r3_jam_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        jam_en |-> !tx_req && !retry_req);

    a_r5_att_limit: assert property (@(posedge clk) disable iff (!rst_n)
        status[CNT_W-1:0] <= CNT_W'(MAX_ATTEMPTS));

    a_r6_abort_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !retry_req && !jam_en);

    a_r7_hold_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !tx_req);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !stat_load) |=> (status == '0) && !irq);
endmodule

bind tx_retry_ctrl tx_retry_chk #(
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (stat_rd),
    .int_mask  (int_mask),
    .tx_req    (tx_req),
    .jam_en    (jam_en),
    .retry_req (retry_req),
    .abort     (abort),
    .status    (status),
    .irq       (irq),
    .stat_load (stat_load)
);

// File: tb/sim_tx_retry_ctrl.sv
// Scoreboard bench: the driver queues expected status words, a monitor
// compares them when a frame result appears.
module sim_tx_retry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LATE  = 16;
    localparam int JAM   = 4;
    localparam int SLOT  = 2;
    localparam int LIMIT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b1;
    logic sof = 0, col = 0, eof = 0, stat_rd = 0, int_mask = 0;
    logic tx_req, jam_en, retry_req, abort, irq;
    logic [7:0] status;

    int compared = 0;
    int mismatched = 0;
    int jam_cnt = 0;
    bit seen = 0;
    bit finished = 0;
    logic [7:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_retry_ctrl #(
        .MAX_ATTEMPTS(16), .LATE_BITS(LATE), .JAM_BITS(JAM),
        .SLOT_BITS(SLOT), .BACKOFF_LIMIT(LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sof(sof), .col(col),
        .eof(eof), .stat_rd(stat_rd), .int_mask(int_mask), .tx_req(tx_req),
        .jam_en(jam_en), .retry_req(retry_req), .abort(abort),
        .status(status), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // monitor: compare each new status word against the queue (R2 R5 R6 R10)
    always @(negedge clk) begin
        if (jam_en) jam_cnt++;
        if (rst_n && status[7] && !seen) begin
            seen = 1;
            if (expq.size() == 0) chk("R10", "unexpected status", status, 0);
            else chk("R10", "status word", status, expq.pop_front());
        end
        if (status == 8'h00) seen = 0;
    end

    task automatic start_frame();
        @(negedge clk) sof = 1;
        @(negedge clk) sof = 0;
    endtask

    task automatic collide_after(input int k);
        repeat (k) @(negedge clk);
        col = 1;
        @(negedge clk) col = 0;
    endtask

    task automatic end_frame(input int k);
        repeat (k) @(negedge clk);
        eof = 1;
        @(negedge clk) eof = 0;
    endtask

    task automatic read_status();
        @(negedge clk) stat_rd = 1;
        @(negedge clk) stat_rd = 0;
    endtask

    // wait for retry or abort after a jam; n counts cycles after the jam
    task automatic outcome(output bit got_retry, output bit got_abort, output int n);
        got_retry = 0; got_abort = 0; n = 0;
        for (int i = 0; i < 200; i++) begin
            if (!jam_en) n++;
            if (retry_req) begin got_retry = 1; break; end
            if (abort) begin got_abort = 1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        bit r, a;
        int n, retries;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "tx_req", tx_req, 1);
        chk("R1", "jam_en", jam_en, 0);
        chk("R1", "status", status, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "retry/abort", {retry_req, abort}, 0);

        // R2 clean frame
        expq.push_back(8'h81);
        start_frame();
        chk("R2", "tx_req during frame", tx_req, 0);
        end_frame(5);
        chk("R2", "irq after frame", irq, 1);
        read_status();
        // R8 read clears
        chk("R8", "status after read", status, 0);
        chk("R8", "irq after read", irq, 0);

        // R3 R4 early collision at tick 15, then success on attempt 2
        expq.push_back(8'h82);
        start_frame();
        jam_cnt = 0;
        collide_after(LATE - 1);
        outcome(r, a, n);
        chk("R3", "early collision retries", {r, a}, 2'b10);
        chk("R3", "jam length", jam_cnt, JAM);
        chk("R4", "backoff within 1 slot", (n <= (1*SLOT + 1)) ? 1 : 0, 1);
        @(negedge clk);
        chk("R3", "tx_req after retry", tx_req, 1);
        start_frame();
        end_frame(3);
        read_status();

        // R6 late collision at tick 16
        expq.push_back(8'hC1);
        start_frame();
        jam_cnt = 0;
        collide_after(LATE);
        outcome(r, a, n);
        chk("R6", "late collision aborts", {r, a}, 2'b01);
        chk("R6", "jam length", jam_cnt, JAM);
        @(negedge clk);
        // R7 hold: sof and col ignored
        chk("R7", "tx_req in hold", tx_req, 0);
        jam_cnt = 0;
        start_frame();
        collide_after(2);
        repeat (JAM + 2) @(negedge clk);
        chk("R7", "no jam during hold", jam_cnt, 0);
        chk("R7", "status kept in hold", status, 8'hC1);
        read_status();
        chk("R7", "tx_req after read", tx_req, 1);

        // R5 sixteen collided attempts
        expq.push_back(8'hB0);
        retries = 0;
        for (int att = 1; att <= 16; att++) begin
            if (att > 1) @(negedge clk);
            start_frame();
            collide_after(3);
            outcome(r, a, n);
            if (r) begin
                retries++;
                chk("R4", "backoff bound", (n <= (((1 << ((att < LIMIT) ? att : LIMIT)) - 1) * SLOT + 1)) ? 1 : 0, 1);
            end
            if (att == 16) chk("R5", "final attempt aborts", {r, a}, 2'b01);
        end
        chk("R5", "retry count", retries, 15);
        repeat (20) @(negedge clk);
        chk("R5", "no retry after abort", retry_req, 0);
        chk("R7", "tx_req held", tx_req, 0);
        read_status();

        // R9 mask
        int_mask = 1;
        expq.push_back(8'h81);
        start_frame();
        end_frame(4);
        chk("R9", "masked irq", irq, 0);
        int_mask = 0;
        @(negedge clk);
        chk("R9", "unmasked irq", irq, 1);
        read_status();
        chk("R8", "irq cleared", irq, 0);
        chk("R10", "queue drained", expq.size(), 0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule